// File: doc/BRIEF.md
# Serial Panel Register Link

This block lets on-chip logic program a display panel's control registers over a three- or four-wire serial link. The wires are an active-low select, a serial clock, a data line toward the panel and an optional return line from it. A client hands over one access at a time on a valid/ready command port. An access is either a register write (an index and a 16-bit value) or a register read (an index only). The block turns each access into chip-select frames on the wires, and it raises a one-cycle completion strobe when the access has finished.

Every frame opens with a fixed device identifier, followed by two flag bits and a 16-bit payload. A write needs two frames: the first names the register and the second carries the value. A read also starts with a frame naming the register. It then runs a longer frame during which the panel drives its answer back on the return line, and the block collects that answer into a 32-bit word. The serial clock is derived from the system clock. A parameter sets the length of each half period.

Top module: `panel_cfg_serial`

## Requirements
- R1: After reset, and whenever no access is in progress, `cs_n_o`, `sclk_o` and `mosi_o` are all 1 and `cmd_ready_o` is 1.
- R2: A normal frame carries 24 bits, most significant first. Bits 23:18 hold the device identifier (`DEV_ID`, 6'h1d by default). Bit 17 is the select flag (0 = index, 1 = value). Bit 16 is the direction flag (0 = write, 1 = read). Bits 15:0 hold the payload.
- R3: A write produces exactly two frames. The first has select 0, direction 0 and the index as payload. The second has select 1, direction 0 and the write value as payload.
- R4: A read produces exactly two frames. The first is the same index frame as in R3. The second has 32 clock periods: its first 24 bits carry select 1, direction 1 and payload 0, and its last 8 bits are 0.
- R5: During the read frame, the block samples `miso_i` once per clock period, at the end of the high phase. It shifts each sample in so that the first bit received ends up at bit 31 of `rdata_o`.
- R6: Within a frame, every low phase and every high phase of `sclk_o` lasts exactly `DIV` system cycles. The time from select falling to the first clock fall is also `DIV` cycles, and so is the time from the last clock rise to select rising. `mosi_o` changes only while `sclk_o` is low or while select is high.
- R7: `cmd_ready_o` is 0 from the cycle after an access is accepted until select has returned high at the end of its last frame. A command is taken only when `cmd_valid_i` and `cmd_ready_o` are both 1.
- R8: Each access ends with `done_o` high for exactly one cycle. `rdata_o` then holds the captured word for a read, or 0 for a write.
- R9: Select falls and rises only while `sclk_o` is high, so every data bit falls inside its frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Access request present |
| cmd_ready_o | output | 1 | Block can take a request |
| cmd_read_i | input | 1 | 1 = register read, 0 = register write |
| cmd_index_i | input | 16 | Register index |
| cmd_data_i | input | 16 | Value to write |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 32 | Read result (0 after a write) |
| cs_n_o | output | 1 | Panel select, active low |
| sclk_o | output | 1 | Serial clock, panel samples on the rise |
| mosi_o | output | 1 | Serial data toward the panel |
| miso_i | input | 1 | Serial data from the panel |

## Verification
The assertions assume that the panel changes `miso_i` only after a clock fall, so the level is stable when the block samples it at the end of a high phase. The bench's panel model follows this rule. It presents the first return bit when select falls and moves to the next bit on each clock fall after a rise. The bench holds `cmd_valid_i` for exactly one cycle while `cmd_ready_o` is high, so every request is taken at a known edge and none is waiting while a frame is in flight.

// File: rtl/panel_link_pkg.sv
package panel_link_pkg;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_LEAD,
        SH_LOW,
        SH_HIGH,
        SH_TRAIL
    } sh_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FIRST,
        SQ_SECOND
    } sq_state_e;

endpackage

// File: rtl/panel_link_shifter.sv
module panel_link_shifter
    import panel_link_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int WORD_W = 32,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  nbits_i,
    input  logic              miso_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              done_o,
    output logic [WORD_W-1:0] rx_o
);
    localparam int DIV_W = $clog2(DIV) + 1;

    typedef struct packed {
        sh_state_e         st;
        logic [DIV_W-1:0]  div;
        logic [CNT_W-1:0]  left;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic              cs_n;
        logic              sclk;
        logic              mosi;
        logic              done;
    } sh_regs_t;

    sh_regs_t r_q, r_d;
    logic     phase_end;

    assign phase_end = (r_q.div == DIV_W'(DIV - 1));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.div  = phase_end ? '0 : r_q.div + 1'b1;
        unique case (r_q.st)
            SH_IDLE: begin
                r_d.div = '0;
                if (start_i) begin
                    r_d.st   = SH_LEAD;
                    r_d.cs_n = 1'b0;
                    r_d.tx   = word_i;
                    r_d.left = nbits_i;
                    r_d.rx   = '0;
                end
            end
            SH_LEAD: begin
                if (phase_end) begin
                    r_d.st   = SH_LOW;
                    r_d.sclk = 1'b0;
                    r_d.mosi = r_q.tx[WORD_W-1];
                    r_d.tx   = {r_q.tx[WORD_W-2:0], 1'b0};
                end
            end
            SH_LOW: begin
                if (phase_end) begin
                    r_d.st   = SH_HIGH;
                    r_d.sclk = 1'b1;
                end
            end
            SH_HIGH: begin
                if (phase_end) begin
                    r_d.rx   = {r_q.rx[WORD_W-2:0], miso_i};
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == CNT_W'(1)) begin
                        r_d.st   = SH_TRAIL;
                        r_d.cs_n = 1'b1;
                        r_d.mosi = 1'b1;
                    end else begin
                        r_d.st   = SH_LOW;
                        r_d.sclk = 1'b0;
                        r_d.mosi = r_q.tx[WORD_W-1];
                        r_d.tx   = {r_q.tx[WORD_W-2:0], 1'b0};
                    end
                end
            end
            SH_TRAIL: begin
                if (phase_end) begin
                    r_d.st   = SH_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= SH_IDLE;
            r_q.cs_n <= 1'b1;
            r_q.sclk <= 1'b1;
            r_q.mosi <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o = r_q.cs_n;
    assign sclk_o = r_q.sclk;
    assign mosi_o = r_q.mosi;
    assign done_o = r_q.done;
    assign rx_o   = r_q.rx;

    // R6
    mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi_o) |-> (!sclk_o || cs_n_o));
    // R6
    rise_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> !cs_n_o);
    // R9
    cs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> sclk_o);
    // R9
    cs_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (sclk_o && mosi_o));

endmodule

// File: rtl/panel_cfg_serial.sv
module panel_cfg_serial
    import panel_link_pkg::*;
#(
    parameter int          DIV        = 4,
    parameter int          FRAME_BITS = 24,
    parameter int          READ_BITS  = 32,
    parameter int          PAYLOAD_W  = 16,
    parameter logic [7:0]  DEV_ID     = 8'h1d
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid_i,
    output logic                 cmd_ready_o,
    input  logic                 cmd_read_i,
    input  logic [PAYLOAD_W-1:0] cmd_index_i,
    input  logic [PAYLOAD_W-1:0] cmd_data_i,
    output logic                 done_o,
    output logic [READ_BITS-1:0] rdata_o,
    output logic                 cs_n_o,
    output logic                 sclk_o,
    output logic                 mosi_o,
    input  logic                 miso_i
);
    localparam int ID_W  = FRAME_BITS - PAYLOAD_W - 2;
    localparam int PAD_W = READ_BITS - FRAME_BITS;
    localparam int CNT_W = $clog2(READ_BITS + 1);

    typedef struct packed {
        sq_state_e            st;
        logic                 is_read;
        logic [PAYLOAD_W-1:0] data;
        logic [READ_BITS-1:0] rdata;
        logic                 done;
        logic                 start;
        logic [READ_BITS-1:0] word;
        logic [CNT_W-1:0]     nbits;
    } sq_regs_t;

    sq_regs_t             s_q, s_d;
    logic                 sh_done;
    logic [READ_BITS-1:0] sh_rx;

    function automatic logic [READ_BITS-1:0] frame_word(
        input logic rs, input logic rw, input logic [PAYLOAD_W-1:0] payload);
        return {DEV_ID[ID_W-1:0], rs, rw, payload, {PAD_W{1'b0}}};
    endfunction

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.start = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (cmd_valid_i) begin
                    s_d.st      = SQ_FIRST;
                    s_d.is_read = cmd_read_i;
                    s_d.data    = cmd_data_i;
                    s_d.start   = 1'b1;
                    s_d.word    = frame_word(1'b0, 1'b0, cmd_index_i);
                    s_d.nbits   = CNT_W'(FRAME_BITS);
                end
            end
            SQ_FIRST: begin
                if (sh_done) begin
                    s_d.st    = SQ_SECOND;
                    s_d.start = 1'b1;
                    if (s_q.is_read) begin
                        s_d.word  = frame_word(1'b1, 1'b1, '0);
                        s_d.nbits = CNT_W'(READ_BITS);
                    end else begin
                        s_d.word  = frame_word(1'b1, 1'b0, s_q.data);
                        s_d.nbits = CNT_W'(FRAME_BITS);
                    end
                end
            end
            SQ_SECOND: begin
                if (sh_done) begin
                    s_d.st    = SQ_IDLE;
                    s_d.done  = 1'b1;
                    s_d.rdata = s_q.is_read ? sh_rx : '0;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= SQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    panel_link_shifter #(
        .DIV    (DIV),
        .WORD_W (READ_BITS),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (s_q.start),
        .word_i  (s_q.word),
        .nbits_i (s_q.nbits),
        .miso_i  (miso_i),
        .cs_n_o  (cs_n_o),
        .sclk_o  (sclk_o),
        .mosi_o  (mosi_o),
        .done_o  (sh_done),
        .rx_o    (sh_rx)
    );

    assign cmd_ready_o = (s_q.st == SQ_IDLE);
    assign done_o      = s_q.done;
    assign rdata_o     = s_q.rdata;

    // R7
    ready_idle_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> (cs_n_o && sclk_o && mosi_o));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    done_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && cmd_ready_o));
    // R7
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready_o && cmd_valid_i) |=> !cmd_ready_o);

endmodule

// File: tb/tb_panel_cfg_serial.sv
module tb_panel_cfg_serial;
    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [15:0] cmd_index = '0;
    logic [15:0] cmd_data = '0;
    logic        cmd_ready, done, cs_n, sclk, mosi;
    logic        miso = 1'b1;
    logic [31:0] rdata;

    int total = 0;
    int bad = 0;

    // monitor state
    logic [31:0] pat = '0;
    logic [31:0] cur;
    int          cbits, rises, evcnt;
    logic        prev_cs = 1'b1, prev_sclk = 1'b1;
    logic [31:0] fr_val [0:3];
    int          fr_bits [0:3];
    int          fcount = 0, ready_bad = 0, phase_bad = 0, edge_bad = 0, done_cnt = 0;
    logic [31:0] got_rdata = '0;

    always #10 clk = ~clk;

    panel_cfg_serial #(.DIV(DIV)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_ready_o (cmd_ready),
        .cmd_read_i  (cmd_read),
        .cmd_index_i (cmd_index),
        .cmd_data_i  (cmd_data),
        .done_o      (done),
        .rdata_o     (rdata),
        .cs_n_o      (cs_n),
        .sclk_o      (sclk),
        .mosi_o      (mosi),
        .miso_i      (miso)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            evcnt = evcnt + 1;
            if (prev_cs && !cs_n) begin
                cur = '0; cbits = 0; rises = 0; evcnt = 0;
                miso = pat[31];
                if (!sclk) edge_bad = edge_bad + 1;
            end
            if (!cs_n && cmd_ready) ready_bad = ready_bad + 1;
            if (sclk != prev_sclk) begin
                if (evcnt != DIV) phase_bad = phase_bad + 1;
                evcnt = 0;
                if (sclk && !cs_n) begin
                    cur = {cur[30:0], mosi};
                    cbits = cbits + 1;
                    rises = rises + 1;
                end else if (!sclk && !cs_n && rises > 0 && rises < 32) begin
                    miso = pat[31 - rises];
                end
            end
            if (!prev_cs && cs_n) begin
                if (evcnt != DIV) phase_bad = phase_bad + 1;
                if (!sclk) edge_bad = edge_bad + 1;
                if (fcount < 4) begin
                    fr_val[fcount]  = cur;
                    fr_bits[fcount] = cbits;
                end
                fcount = fcount + 1;
            end
            if (done) begin
                done_cnt = done_cnt + 1;
                got_rdata = rdata;
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] hdr(input logic rs, input logic rw, input logic [15:0] p);
        return {6'h1d, rs, rw, p};
    endfunction

    task automatic access(input logic rd, input logic [15:0] idx, input logic [15:0] dat, input logic [31:0] p);
        fcount = 0; ready_bad = 0; phase_bad = 0; edge_bad = 0; done_cnt = 0;
        pat = p;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = rd; cmd_index = idx; cmd_data = dat;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (done_cnt == 0) @(negedge clk);
        @(negedge clk);
        // R3 R4: two frames
        chk(fcount == 2, "R3/R4 frame count", 32'(fcount), 32'd2);
        // R2: index frame layout
        chk(fr_bits[0] == 24 && fr_val[0][23:0] == hdr(1'b0, 1'b0, idx), "R2 index frame",
            fr_val[0], {8'h0, hdr(1'b0, 1'b0, idx)});
        if (rd) begin
            // R4
            chk(fr_bits[1] == 32 && fr_val[1] == {hdr(1'b1, 1'b1, 16'h0), 8'h00}, "R4 read frame",
                fr_val[1], {hdr(1'b1, 1'b1, 16'h0), 8'h00});
            // R5
            chk(got_rdata == p, "R5 read data", got_rdata, p);
        end else begin
            // R3
            chk(fr_bits[1] == 24 && fr_val[1][23:0] == hdr(1'b1, 1'b0, dat), "R3 data frame",
                fr_val[1], {8'h0, hdr(1'b1, 1'b0, dat)});
            // R8: write returns zero
            chk(got_rdata == 32'h0, "R8 write rdata", got_rdata, 32'h0);
        end
        chk(done_cnt == 1, "R8 done pulses", 32'(done_cnt), 32'd1);
        chk(ready_bad == 0, "R7 ready during frame", 32'(ready_bad), 32'd0);
        chk(phase_bad == 0, "R6 phase length", 32'(phase_bad), 32'd0);
        chk(edge_bad == 0, "R9 select edges", 32'(edge_bad), 32'd0);
        chk(cs_n && sclk && mosi && cmd_ready, "R1 idle after access",
            {28'h0, cs_n, sclk, mosi, cmd_ready}, 32'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cs_n && sclk && mosi && cmd_ready && !done, "R1 reset state",
            {27'h0, cs_n, sclk, mosi, cmd_ready, done}, 32'h1E);
        for (int k = 0; k < 16; k++) begin
            access(1'b0, 16'((k << 12) | (k * 3)),
                   16'((16'h1 << k) ^ ((k % 2) ? 16'hFFFF : 16'h0)), 32'h0);
            access(1'b1, 16'(16'hFFFF - k),
                   16'h0, (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF
                                 : (32'h9E37_79B9 * (k + 1)) ^ (32'h1 << k));
        end
        access(1'b0, 16'hFFFF, 16'hFFFF, 32'h0);
        access(1'b0, 16'h0000, 16'h0000, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd150000, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule